// File: doc/BRIEF.md
# Cartridge Save-RAM Address Translator

This block sits between a 24-bit CPU bus and a battery-backed save RAM. It also serves a separate work RAM. An upstream decoder has already classified each access into a window type. This block turns the bus address into a linear RAM address, using the folding rule for that window type, and trims the result with a size mask that reflects how much RAM is fitted. It drives the RAM write enable and the write data.

When no save RAM is fitted, the size mask is zero and writes are suppressed. Any write that actually lands in RAM raises a sticky modified flag. System logic reads this flag to decide when the battery RAM needs saving, and it clears the flag with a one-cycle pulse.

Reads return the RAM data when the window is mapped. When the window is unmapped, a read returns the value of an open-bus register. That register holds the data of the most recent mapped read.

Top module: `saveram_xlat`

## Requirements
- R1: Window select encoding is 2 bits: 0 = unmapped, 1 = interleaved-bank (low) save RAM, 2 = high-bank save RAM, 3 = work RAM.
- R2: In the low window, `ram_addr` = ((bank << 15) | addr[14:0]) & `size_mask`, where bank = addr[23:16]. The result is combinational in the same cycle.
- R3: In the high window, `ram_addr` = (addr[14:0] - 0x6000 + addr[19:16] * 0x2000) & `size_mask`. The sum is taken modulo the RAM address width.
- R4: In the work window, `ram_addr` = (addr[14:0] - 0x6000), taken modulo the RAM address width, with no mask applied.
- R5: A write in the low or high window while `size_mask` is zero leaves `ram_we` low and does not set the modified flag.
- R6: `ram_we` is high in the same cycle as `wr_en` when the window is work RAM, or when it is low or high with a nonzero mask. `ram_wdata` then equals `wr_data`. `ram_we` is never high in the unmapped window or without `wr_en`.
- R7: `dirty` rises on the clock edge that follows any cycle with `ram_we` high. It stays high until cleared.
- R8: A `dirty_clr` pulse clears `dirty` on the next edge, unless a write takes effect in that same cycle, in which case `dirty` stays set.
- R9: A read in a mapped window returns `ram_rdata` on `rd_data` in the same cycle. The open-bus register captures that value on the next edge.
- R10: A read in the unmapped window returns the open-bus register on `rd_data` and leaves the register unchanged.
- R11: After reset, `dirty` is 0 and the open-bus register is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 24 | CPU bus address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| win_sel | input | 2 | Window type (R1 encoding) |
| size_mask | input | RAM_AW | Save-RAM size mask |
| wr_data | input | 8 | Write data from CPU |
| ram_rdata | input | 8 | Read data from RAM |
| dirty_clr | input | 1 | Pulse to clear the modified flag |
| ram_addr | output | RAM_AW | Linear RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| rd_data | output | 8 | Read data to CPU |
| dirty | output | 1 | Sticky modified flag |

## Verification
The bench targets high-window addresses below 0x6000, where the subtraction wraps. A design that does not fold this modulo the RAM width would return the wrong RAM address. It also drives low-window banks with bit 0 set: if the bank shift is misplaced, those banks alias onto even banks. Writes with a zero mask are included, to catch a design that still pulses the write enable or marks the RAM modified. Clear pulses are issued both alone and together with a write, so that a reversed priority would lose a dirty indication. Unmapped reads follow mapped reads, to confirm that the open-bus value is the last mapped data and is not disturbed by the unmapped access itself.

// File: rtl/saveram_xlat_pkg.sv
package saveram_xlat_pkg;
    localparam int DATA_W = 8;
    localparam int CPU_AW = 24;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_LOW  = 2'd1,
        WIN_HIGH = 2'd2,
        WIN_WORK = 2'd3
    } win_e;

    typedef struct packed {
        logic              dirty;
        logic [DATA_W-1:0] obus;
    } xlat_state_t;
endpackage

// File: rtl/saveram_fold.sv
module saveram_fold
    import saveram_xlat_pkg::*;
#(
    parameter int RAM_AW = 17
) (
    input  logic [CPU_AW-1:0] addr,
    input  win_e              win,
    input  logic [RAM_AW-1:0] mask,
    output logic [RAM_AW-1:0] lin_addr
);
    localparam logic [CPU_AW-1:0] WORK_BASE = CPU_AW'(24'h6000);

    logic [CPU_AW-1:0] low_raw_d;
    logic [CPU_AW-1:0] high_raw_d;
    logic [CPU_AW-1:0] work_raw_d;
    logic [CPU_AW-1:0] offs_d;

    always_comb begin
        offs_d     = {9'b0, addr[14:0]};
        low_raw_d  = {1'b0, addr[23:16], addr[14:0]};
        high_raw_d = offs_d - WORK_BASE + {7'b0, addr[19:16], 13'b0};
        work_raw_d = offs_d - WORK_BASE;
        unique case (win)
            WIN_LOW:  lin_addr = low_raw_d[RAM_AW-1:0] & mask;
            WIN_HIGH: lin_addr = high_raw_d[RAM_AW-1:0] & mask;
            WIN_WORK: lin_addr = work_raw_d[RAM_AW-1:0];
            default:  lin_addr = '0;
        endcase
    end

    logic unused_fold_bits;
    assign unused_fold_bits = ^{addr[15], low_raw_d[CPU_AW-1:RAM_AW],
                                high_raw_d[CPU_AW-1:RAM_AW], work_raw_d[CPU_AW-1:RAM_AW]};
endmodule

// File: rtl/saveram_wgate.sv
module saveram_wgate
    import saveram_xlat_pkg::*;
#(
    parameter int RAM_AW = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  win_e              win,
    input  logic              wr_en,
    input  logic [RAM_AW-1:0] mask,
    output logic              we
);
    logic mask_present;

    always_comb begin
        mask_present = |mask;
        unique case (win)
            WIN_LOW, WIN_HIGH: we = wr_en & mask_present;
            WIN_WORK:          we = wr_en;
            default:           we = 1'b0;
        endcase
    end

    // R5: an absent save RAM never sees a write
    a_r5_no_ram_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((win == WIN_LOW || win == WIN_HIGH) && mask == '0) |-> !we);
    // R6: unmapped window or idle strobe never writes
    a_r6_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        (win == WIN_NONE || !wr_en) |-> !we);
endmodule

// File: rtl/saveram_state.sv
module saveram_state
    import saveram_xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              clr,
    input  logic              rd_mapped,
    input  logic [DATA_W-1:0] rd_value,
    output logic              dirty,
    output logic [DATA_W-1:0] obus
);
    xlat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.dirty = 1'b0;
        if (we)
            st_d.dirty = 1'b1;
        if (rd_mapped)
            st_d.obus = rd_value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign dirty = st_q.dirty;
    assign obus  = st_q.obus;

    // R7: effective write marks RAM modified
    a_r7_dirty_set: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> dirty);
    // R7: flag holds without a clear
    a_r7_dirty_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty && !clr) |=> dirty);
    // R8: clear without a write drops the flag
    a_r8_dirty_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !we) |=> !dirty);
    // R10: open-bus value holds when no mapped read
    a_r10_obus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_mapped |=> $stable(obus));
endmodule

// File: rtl/saveram_xlat.sv
module saveram_xlat
    import saveram_xlat_pkg::*;
#(
    parameter int RAM_AW = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [23:0]       bus_addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [1:0]        win_sel,
    input  logic [RAM_AW-1:0] size_mask,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        ram_rdata,
    input  logic              dirty_clr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we,
    output logic [7:0]        ram_wdata,
    output logic [7:0]        rd_data,
    output logic              dirty
);
    win_e              win;
    logic              rd_mapped;
    logic [DATA_W-1:0] obus;

    assign win       = win_e'(win_sel);
    assign rd_mapped = rd_en && (win != WIN_NONE);

    saveram_fold #(.RAM_AW(RAM_AW)) u_fold (
        .addr     (bus_addr),
        .win      (win),
        .mask     (size_mask),
        .lin_addr (ram_addr)
    );

    saveram_wgate #(.RAM_AW(RAM_AW)) u_wgate (
        .clk   (clk),
        .rst_n (rst_n),
        .win   (win),
        .wr_en (wr_en),
        .mask  (size_mask),
        .we    (ram_we)
    );

    saveram_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (ram_we),
        .clr       (dirty_clr),
        .rd_mapped (rd_mapped),
        .rd_value  (ram_rdata),
        .dirty     (dirty),
        .obus      (obus)
    );

    assign ram_wdata = wr_data;
    assign rd_data   = rd_mapped ? ram_rdata : obus;

    // R9: a mapped read is captured into the open-bus register
    a_r9_obus_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mapped |=> (obus == $past(ram_rdata)));
    // R10: unmapped read presents the held value
    a_r10_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && win == WIN_NONE) |-> (rd_data == obus));
endmodule

// File: tb/saveram_xlat_tb_top.sv
module saveram_xlat_tb_top;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [23:0]   bus_addr = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    win_sel = '0;
    logic [AW-1:0] size_mask = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    ram_rdata = '0;
    logic          dirty_clr = 1'b0;
    logic [AW-1:0] ram_addr;
    logic          ram_we;
    logic [7:0]    ram_wdata;
    logic [7:0]    rd_data;
    logic          dirty;

    int n_checks = 0;
    int n_fail   = 0;
    bit m_dirty  = 1'b0;
    int m_obus   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    saveram_xlat #(.RAM_AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rd_en(rd_en), .wr_en(wr_en),
        .win_sel(win_sel), .size_mask(size_mask), .wr_data(wr_data), .ram_rdata(ram_rdata),
        .dirty_clr(dirty_clr), .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .rd_data(rd_data), .dirty(dirty)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int ref_addr(input int w, input int a, input int m);
        int off, r;
        off = a & 'h7fff;
        case (w)
            1: r = ((((a >> 16) & 'hff) * 32768) | off) & m;
            2: r = (off - 'h6000 + ((a >> 16) & 'hf) * 8192) & m;
            3: r = (off - 'h6000) & ((1 << AW) - 1);
            default: r = 0;
        endcase
        return r;
    endfunction

    task automatic step(input int w, input int a, input bit rd, input bit wr,
                        input int m, input int wd, input int rdv, input bit clr);
        bit exp_we;
        string tg;
        @(negedge clk);
        win_sel = 2'(w); bus_addr = 24'(a); rd_en = rd; wr_en = wr;
        size_mask = AW'(m); wr_data = 8'(wd); ram_rdata = 8'(rdv); dirty_clr = clr;
        #2;
        tg = (w == 1) ? "R2 low fold" : (w == 2) ? "R3 high fold" : "R4 work fold";
        if (w != 0) chk(tg, int'(ram_addr), ref_addr(w, a, m));
        exp_we = wr && (w == 3 || ((w == 1 || w == 2) && m != 0));
        chk((wr && m == 0 && (w == 1 || w == 2)) ? "R5 suppressed write" : "R6 write enable",
            int'(ram_we), int'(exp_we));
        if (exp_we) chk("R6 write data", int'(ram_wdata), wd & 'hff);
        if (rd && w != 0) chk("R9 mapped read", int'(rd_data), rdv & 'hff);
        if (rd && w == 0) chk("R10 unmapped read", int'(rd_data), m_obus);
        chk("R7 R8 dirty flag", int'(dirty), int'(m_dirty));
        if (clr) m_dirty = 1'b0;
        if (exp_we) m_dirty = 1'b1;
        if (rd && w != 0) m_obus = rdv & 'hff;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #3;
        chk("R11 reset dirty", int'(dirty), 0);
        rst_n = 1'b1;
        // R11 reset open-bus: unmapped read returns 0x00
        step(0, 'h123456, 1, 0, 'h1ffff, 0, 'hee, 0);
        // R2 odd and even banks, R1 encoding
        step(1, 'h016abc, 1, 0, 'h1ffff, 0, 'h11, 0);
        step(1, 'h037fff, 1, 0, 'h1ffff, 0, 'h22, 0);
        step(1, 'hf08001, 1, 0, 'h07fff, 0, 'h33, 0);
        // R3 including wrap below 0x6000
        step(2, 'h306000, 1, 0, 'h1ffff, 0, 'h44, 0);
        step(2, 'h2f7fff, 1, 0, 'h1ffff, 0, 'h45, 0);
        step(2, 'h001234, 1, 0, 'h1ffff, 0, 'h46, 0);
        // R10 unmapped read after mapped read
        step(0, 'h000000, 1, 0, 'h1ffff, 0, 'h99, 0);
        // R5 zero mask writes
        step(1, 'h00_7000, 0, 1, 0, 'h5a, 0, 0);
        step(2, 'h31_6000, 0, 1, 0, 'h5b, 0, 0);
        step(0, 'h00_7000, 0, 1, 'h1ffff, 'h5c, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        // R6 R7 write and stickiness
        step(1, 'h05_1234, 0, 1, 'h1ffff, 'hc3, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        // R8 clear alone, then clear with write
        step(0, 0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(3, 'h00_6abc, 0, 1, 0, 'h7e, 0, 1);
        step(3, 'h00_1000, 1, 0, 0, 0, 'h0f, 1);
        step(0, 0, 1, 0, 0, 0, 'hab, 0);
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            int w, a;
            w = $urandom_range(0, 3);
            a = int'($urandom) & 'hffffff;
            step(w, a, $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0,
                 ($urandom_range(0, 4) == 0) ? 0 : ((1 << $urandom_range(1, AW)) - 1),
                 int'($urandom) & 'hff, int'($urandom) & 'hff, $urandom_range(0, 5) == 0);
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule